// File: doc/BRIEF.md
# Synchronous FIFO with Read-Pointer Rewind

This block is a single-clock first-in first-out buffer. Writes go into a memory array at the write pointer. Reads come out of the same array at the read pointer, and the data appears on a registered output. The full and empty flags come only from the two pointers. The pointers carry one bit more than the address, so that a buffer holding nothing and a buffer holding every slot can be told apart.

The block supports packet replay. Driving `rewind_n` low moves the read pointer back to slot zero. While `rewind_n` is low, and for a configurable settling interval after it goes high again, every read and write request is dropped and `ready` is low. Once `ready` returns, reads deliver the stored words again from the first one. They continue until the read pointer meets the write pointer, and any word written after the rewind follows in order.

Replay is only valid when the words written since reset fit in the buffer and at least one word has been read.

Top module: `rtfifo_top`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers clear. After that edge `empty`=1, `full`=0, `ready`=1 and `rd_data`=0.
- R2: Words are read back in the order they were written. An accepted read (`rd_en`=1, `ready`=1, `rewind_n`=1, `empty`=0 at an edge) updates `rd_data` at that same edge.
- R3: After DEPTH accepted writes with no read, `full`=1. A write request while `full`=1 stores nothing, so DEPTH reads later `empty`=1.
- R4: A read request while `empty`=1 leaves `rd_data` and the flags unchanged.
- R5: A clock edge that samples `rewind_n`=0 sets the read pointer to slot 0. The next reads then return the words from the first one written since reset.
- R6: `ready` is 0 after any edge that samples `rewind_n`=0. It stays 0 until RECOVER_CYC edges have passed after the first edge that samples `rewind_n`=1. Read and write requests in that whole span are ignored.
- R7: The flags follow the pointers after a rewind. With DEPTH words written since reset, `full`=1 again. With fewer than DEPTH words written, `empty`=0 and `full`=0.
- R8: Words written after a rewind are read out after the replayed words, in write order.
- R9: Replay stops where the write pointer stands: after the last written word has been read, `empty`=1.
- R10: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read |
| rewind_n | input | 1 | Active-low rewind of the read pointer |
| full | output | 1 | Every slot holds unread data |
| empty | output | 1 | No unread data |
| ready | output | 1 | Requests are accepted this cycle |

## Verification
A read pointer left in the wrong place after a rewind shows at once. The first read after `ready` returns gives a word other than the first one stored, and the flags differ from the expected ones on the cycle before that read. A write pointer that moves during the hold or the settling interval adds a word that nobody wrote. That word shows up in the replayed sequence, and `empty` no longer rises after the expected count. A settling counter that is off by one moves the rise of `ready` by one cycle, and the edge-by-edge check of `ready` catches it.

// File: rtl/rtfifo_pkg.sv
`timescale 1ns/1ps
package rtfifo_pkg;

    // Phases of the rewind controller
    typedef enum logic [1:0] {
        RT_RUN    = 2'd0,
        RT_HOLD   = 2'd1,
        RT_SETTLE = 2'd2
    } rt_state_e;

    // Request bundle passed from the edge into the pointer logic
    typedef struct packed {
        logic wr;
        logic rd;
    } op_req_t;

    // Accept/fire strobes produced by the pointer logic
    typedef struct packed {
        logic wr;
        logic rd;
    } op_fire_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rtfifo_ctrl.sv
`timescale 1ns/1ps
module rtfifo_ctrl
    import rtfifo_pkg::*;
#(
    parameter int unsigned RECOVER_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rewind_n,
    output logic rewind,
    output logic ready
);
    localparam int unsigned CNT_W = cnt_width(RECOVER_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_CYC - 1);

    rt_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RT_RUN;
            cnt_q   <= '0;
        end else if (!rewind_n) begin
            state_q <= RT_HOLD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                RT_HOLD: begin
                    state_q <= RT_SETTLE;
                    cnt_q   <= '0;
                end
                RT_SETTLE: begin
                    if (cnt_q == LAST) state_q <= RT_RUN;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= RT_RUN;
            endcase
        end
    end

    assign rewind = !rewind_n;
    assign ready  = (state_q == RT_RUN);

    // R6
    hold_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !rewind_n |=> !ready);
    // R6
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(rewind_n));

endmodule

// File: rtl/rtfifo_ptrs.sv
`timescale 1ns/1ps
module rtfifo_ptrs
    import rtfifo_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_req_t           req,
    input  logic              go,
    input  logic              rewind,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output op_fire_t          fire,
    output logic              full,
    output logic              empty
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wptr_q, rptr_q;

    assign empty = (wptr_q == rptr_q);
    assign full  = (wptr_q[ADDR_W] != rptr_q[ADDR_W]) &&
                   (wptr_q[ADDR_W-1:0] == rptr_q[ADDR_W-1:0]);

    assign fire.wr = req.wr && go && !full;
    assign fire.rd = req.rd && go && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (fire.wr) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rewind) begin
            rptr_q <= '0;
        end else if (fire.rd) begin
            rptr_q <= rptr_q + 1'b1;
        end
    end

    assign waddr = wptr_q[ADDR_W-1:0];
    assign raddr = rptr_q[ADDR_W-1:0];

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && req.wr) |=> $stable(wptr_q));
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !rewind) |=> $stable(rptr_q));
    // R5
    rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rptr_q == '0));
    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: rtl/rtfifo_store.sv
`timescale 1ns/1ps
module rtfifo_store
    import rtfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_fire_t          fire,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (fire.wr && (waddr == ADDR_W'(g))) mem_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata <= '0;
        else if (fire.rd) rdata <= mem_q[raddr];
    end

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire.rd |=> $stable(rdata));

endmodule

// File: rtl/rtfifo_top.sv
`timescale 1ns/1ps
module rtfifo_top
    import rtfifo_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned RECOVER_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rewind_n,
    output logic              full,
    output logic              empty,
    output logic              ready
);
    op_req_t           req;
    op_fire_t          fire;
    logic              rewind;
    logic              go;
    logic [ADDR_W-1:0] waddr, raddr;

    assign req.wr = wr_en;
    assign req.rd = rd_en;
    assign go     = ready && rewind_n;

    rtfifo_ctrl #(.RECOVER_CYC(RECOVER_CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rewind_n (rewind_n),
        .rewind   (rewind),
        .ready    (ready)
    );

    rtfifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .go     (go),
        .rewind (rewind),
        .waddr  (waddr),
        .raddr  (raddr),
        .fire   (fire),
        .full   (full),
        .empty  (empty)
    );

    rtfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .waddr (waddr),
        .raddr (raddr),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    // R6
    blocked_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        !go |-> !(fire.wr || fire.rd));

endmodule

// File: tb/test_rtfifo_top.sv
`timescale 1ns/1ps
module test_rtfifo_top;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned RCY    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rewind_n = 1'b1;
    logic              full, empty, ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rtfifo_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RECOVER_CYC(RCY)) i_rtfifo_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rewind_n(rewind_n),
        .full(full), .empty(empty), .ready(ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; rewind_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input int v);
        wr_en = 1'b1; wr_data = DATA_W'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input int exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, int'(rd_data), exp);
    endtask

    // Rewind with read and write requests held high the whole time (R6)
    task automatic rewind_seq();
        int held;
        held = int'(rd_data);
        rewind_n = 1'b0; wr_en = 1'b1; rd_en = 1'b1; wr_data = 16'hDEAD;
        @(negedge clk);
        @(negedge clk);
        chk("R6 ready low in hold", int'(ready), 0);
        rewind_n = 1'b1;
        for (int i = 0; i < RCY; i++) begin
            @(negedge clk);
            chk("R6 ready low in settle", int'(ready), 0);
        end
        @(negedge clk);
        chk("R6 ready back", int'(ready), 1);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R6 rd_data untouched", int'(rd_data), held);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 ready", int'(ready), 1);
        chk("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_order();
        do_reset();
        push(16'h0A1); push(16'h0B2); push(16'h0C3);
        chk("R2 not empty", int'(empty), 0);
        pop_chk("R2 first", 16'h0A1);
        pop_chk("R2 second", 16'h0B2);
        pop_chk("R2 third", 16'h0C3);
        chk("R2 empty after", int'(empty), 1);
    endtask

    task automatic t_empty_read();
        // continues from t_order: buffer empty, rd_data = 0x0C3
        pop_chk("R4 read on empty", 16'h0C3);
        chk("R4 still empty", int'(empty), 1);
        chk("R10 flags", int'(full & empty), 0);
    endtask

    task automatic t_full_replay();
        do_reset();
        for (int i = 0; i <= DEPTH; i++) push(16'h100 + i);
        chk("R3 full", int'(full), 1);
        chk("R10 flags full", int'(full & empty), 0);
        for (int i = 0; i < 3; i++) pop_chk("R2 pre-rewind read", 16'h100 + i);
        chk("R3 full cleared", int'(full), 0);
        rewind_seq();
        chk("R7 full after rewind", int'(full), 1);
        chk("R7 not empty", int'(empty), 0);
        for (int i = 0; i < DEPTH; i++) pop_chk("R5 replay", 16'h100 + i);
        chk("R3 extra write dropped", int'(empty), 1);
    endtask

    task automatic t_mid_replay();
        do_reset();
        for (int i = 0; i < 4; i++) push(16'h200 + i);
        for (int i = 0; i < 4; i++) pop_chk("R2 read", 16'h200 + i);
        chk("R9 empty before rewind", int'(empty), 1);
        rewind_seq();
        chk("R7 empty cleared", int'(empty), 0);
        chk("R7 not full", int'(full), 0);
        push(16'h210); push(16'h211);
        for (int i = 0; i < 4; i++) pop_chk("R5 replay", 16'h200 + i);
        pop_chk("R8 new after rewind", 16'h210);
        pop_chk("R8 new after rewind", 16'h211);
        chk("R9 empty at write pointer", int'(empty), 1);
    endtask

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_full_replay();
        t_mid_replay();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule